// File: doc/BRIEF.md
# Multithread Fetch Priority Selector

This block picks the hardware threads that may fetch in the next cycle. It takes a per-thread snapshot of four instruction queues: integer reservation stations, floating-point reservation stations, the load queue and the store queue. From that snapshot it builds a score for each thread. For every queue the thread occupies, the score adds the number of entries younger than the thread's oldest entry. A thread whose oldest work sits near the tail has few younger entries, so it receives a low score. The block grants first to the lowest score.

Per-thread status inputs remove threads from the grant. These inputs are an instruction-cache miss, a stall that persists, and a run of return fetches longer than the return-address stack depth. After the first grant, the block picks a second grant from a different fetch bank. Both grants are one-hot vectors with their own valid flags. They are registered, so they appear one clock after the inputs that produced them.

Top module: `fetch_prio_sel`

## Requirements
- R1: The score of thread t is the sum, over all queues q in which `q_has[q*NTHR+t]` is 1, of `q_cnt` of queue q minus `q_pos` of (q,t). A queue where the thread has no entry adds zero. Queue q occupies `q_cnt[q*CNT_W +: CNT_W]`, and the pair (q,t) occupies `q_pos[(q*NTHR+t)*CNT_W +: CNT_W]`.
- R2: `gnt0` is the one-hot vector of the eligible thread with the smallest score. Equal scores resolve to the lower thread index.
- R3: `gnt1` is the eligible thread with the smallest score among those other than the `gnt0` thread whose bank (`bank[t*BANK_W +: BANK_W]`) differs from the `gnt0` thread's bank. Closer-ranked threads that share that bank are skipped. Ties resolve to the lower index.
- R4: `gnt0_vld` is 0 when no thread is eligible. `gnt1_vld` is 0 when no thread qualifies under R3. A grant vector is all zeros whenever its valid flag is 0. Each grant vector has at most one bit set.
- R5: A thread with `ic_miss` high in a cycle is not eligible in that cycle.
- R6: A thread with `stall` high in a cycle is not eligible if `stall` was also high in the previous cycle. A stall lasting a single cycle leaves the thread eligible.
- R7: Each thread keeps a count of consecutive return fetches. A cycle with `fetch_vld` and `fetch_ret` both high adds one. A cycle with `fetch_vld` high and `fetch_ret` low clears the count. A cycle with `fetch_vld` low leaves it unchanged. The thread is not eligible while the count is above `RAS_DEPTH` (default 4).
- R8: The grants reflect the inputs sampled at the previous rising clock edge and do not change between edges. While `rst_n` is low, both grants and both valid flags are 0. Reset also clears the stall history and the return counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_cnt | input | NQ*CNT_W | Valid entry count of each queue |
| q_has | input | NQ*NTHR | Thread has at least one entry in the queue |
| q_pos | input | NQ*NTHR*CNT_W | Distance from queue head to the thread's oldest entry |
| ic_miss | input | NTHR | Instruction-cache miss per thread |
| stall | input | NTHR | Stall per thread |
| fetch_vld | input | NTHR | Thread fetched this cycle |
| fetch_ret | input | NTHR | The fetch is a return that hit in the branch target buffer |
| bank | input | NTHR*BANK_W | Fetch bank of each thread |
| gnt0 | output | NTHR | First grant, one-hot |
| gnt0_vld | output | 1 | First grant valid |
| gnt1 | output | NTHR | Second grant, one-hot |
| gnt1_vld | output | 1 | Second grant valid |

## Verification
The bench builds score ties and checks that a design favouring the higher index, or one using a strict-versus-equal comparison in the wrong direction, picks the wrong thread. It places the two next-ranked threads in the first grant's bank. A selector without bank skipping would then grant a conflicting thread, and one that gave up after a single conflict would drop the second grant. It holds a stall for one cycle and then for two, to catch a design that removes a thread on the first stall cycle or never removes it. It runs a return sequence past the stack depth, then a plain fetch, to expose an off-by-one exclusion threshold or a count that is never cleared. It also checks that reset clears that count.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int FPS_NTHR      = 4;
  localparam int FPS_NQ        = 4;
  localparam int FPS_CNT_W     = 5;
  localparam int FPS_RAS_DEPTH = 4;
  localparam int FPS_BANK_W    = 1;

  // Queue slots of the snapshot; the score treats them alike.
  typedef enum int {
    QS_INT_RS = 0,
    QS_FP_RS  = 1,
    QS_LOAD   = 2,
    QS_STORE  = 3
  } fps_queue_e;
endpackage

// File: rtl/fps_score.sv
module fps_score #(
  parameter int NTHR  = 4,
  parameter int NQ    = 4,
  parameter int CNT_W = 5,
  parameter int SC_W  = 7
) (
  input  logic [NQ*CNT_W-1:0]      q_cnt,
  input  logic [NQ*NTHR-1:0]       q_has,
  input  logic [NQ*NTHR*CNT_W-1:0] q_pos,
  output logic [NTHR*SC_W-1:0]     score
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [SC_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int q = 0; q < NQ; q++) begin
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] p;
        c = q_cnt[q*CNT_W +: CNT_W];
        p = q_pos[(q*NTHR+t)*CNT_W +: CNT_W];
        // R1: younger entries behind the oldest one; absent queue adds zero
        if (q_has[q*NTHR+t] && (p < c))
          acc = acc + SC_W'(c - p);
      end
    end
    assign score[t*SC_W +: SC_W] = acc;
  end
endmodule

// File: rtl/fps_elig.sv
module fps_elig #(
  parameter int NTHR      = 4,
  parameter int RAS_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] ic_miss,
  input  logic [NTHR-1:0] stall,
  input  logic [NTHR-1:0] fetch_vld,
  input  logic [NTHR-1:0] fetch_ret,
  output logic [NTHR-1:0] elig
);
  localparam int PC_W = $clog2(RAS_DEPTH + 2);
  localparam logic [PC_W-1:0] PC_SAT = PC_W'(RAS_DEPTH + 1);
  localparam logic [PC_W-1:0] PC_LIM = PC_W'(RAS_DEPTH);

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic            stall_q, stall_d;
    logic [PC_W-1:0] pops_q, pops_d;

    always_comb begin
      stall_d = stall[t];
      pops_d  = pops_q;
      if (fetch_vld[t]) begin
        if (!fetch_ret[t])        pops_d = '0;           // R7 clear
        else if (pops_q != PC_SAT) pops_d = pops_q + 1'b1; // R7 count
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stall_q <= 1'b0;
        pops_q  <= '0;
      end else begin
        stall_q <= stall_d;
        pops_q  <= pops_d;
      end
    end

    assign elig[t] = !ic_miss[t]                 // R5
                   && !(stall[t] && stall_q)     // R6
                   && !(pops_q > PC_LIM);        // R7
  end
endmodule

// File: rtl/fps_pick.sv
module fps_pick #(
  parameter int NTHR = 4,
  parameter int SC_W = 7
) (
  input  logic [NTHR-1:0]      cand,
  input  logic [NTHR*SC_W-1:0] score,
  output logic [NTHR-1:0]      pick,
  output logic                 found
);
  logic [SC_W-1:0] best;
  always_comb begin
    pick  = '0;
    found = 1'b0;
    best  = '0;
    for (int t = 0; t < NTHR; t++) begin
      // strict less-than keeps the lower index on equal scores (R2)
      if (cand[t] && (!found || (score[t*SC_W +: SC_W] < best))) begin
        pick  = '0;
        pick[t] = 1'b1;
        found = 1'b1;
        best  = score[t*SC_W +: SC_W];
      end
    end
  end
endmodule

// File: rtl/fetch_prio_sel.sv
module fetch_prio_sel
  import fps_pkg::*;
#(
  parameter int NTHR      = FPS_NTHR,
  parameter int NQ        = FPS_NQ,
  parameter int CNT_W     = FPS_CNT_W,
  parameter int RAS_DEPTH = FPS_RAS_DEPTH,
  parameter int BANK_W    = FPS_BANK_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NQ*CNT_W-1:0]      q_cnt,
  input  logic [NQ*NTHR-1:0]       q_has,
  input  logic [NQ*NTHR*CNT_W-1:0] q_pos,
  input  logic [NTHR-1:0]          ic_miss,
  input  logic [NTHR-1:0]          stall,
  input  logic [NTHR-1:0]          fetch_vld,
  input  logic [NTHR-1:0]          fetch_ret,
  input  logic [NTHR*BANK_W-1:0]   bank,
  output logic [NTHR-1:0]          gnt0,
  output logic                     gnt0_vld,
  output logic [NTHR-1:0]          gnt1,
  output logic                     gnt1_vld
);
  localparam int SC_W = CNT_W + $clog2(NQ) + 1;

  logic [NTHR*SC_W-1:0] score;
  logic [NTHR-1:0]      elig, pick0, pick1, cand1;
  logic                 found0, found1;
  logic [BANK_W-1:0]    bank0;

  fps_score #(.NTHR(NTHR), .NQ(NQ), .CNT_W(CNT_W), .SC_W(SC_W)) u_score (
    .q_cnt(q_cnt), .q_has(q_has), .q_pos(q_pos), .score(score)
  );

  fps_elig #(.NTHR(NTHR), .RAS_DEPTH(RAS_DEPTH)) u_elig (
    .clk(clk), .rst_n(rst_n), .ic_miss(ic_miss), .stall(stall),
    .fetch_vld(fetch_vld), .fetch_ret(fetch_ret), .elig(elig)
  );

  fps_pick #(.NTHR(NTHR), .SC_W(SC_W)) u_pick0 (
    .cand(elig), .score(score), .pick(pick0), .found(found0)
  );

  // R3: second candidates exclude the first pick and its bank
  always_comb begin
    bank0 = '0;
    for (int t = 0; t < NTHR; t++)
      if (pick0[t]) bank0 = bank[t*BANK_W +: BANK_W];
    for (int t = 0; t < NTHR; t++)
      cand1[t] = elig[t] && !pick0[t] && (bank[t*BANK_W +: BANK_W] != bank0);
  end

  fps_pick #(.NTHR(NTHR), .SC_W(SC_W)) u_pick1 (
    .cand(cand1), .score(score), .pick(pick1), .found(found1)
  );

  logic [NTHR-1:0] gnt0_d, gnt1_d;
  logic            gnt0_vld_d, gnt1_vld_d;

  always_comb begin
    gnt0_d     = pick0;
    gnt0_vld_d = found0;
    gnt1_d     = pick1;
    gnt1_vld_d = found1;
  end

  // R8: registered grants
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt0     <= '0;
      gnt0_vld <= 1'b0;
      gnt1     <= '0;
      gnt1_vld <= 1'b0;
    end else begin
      gnt0     <= gnt0_d;
      gnt0_vld <= gnt0_vld_d;
      gnt1     <= gnt1_d;
      gnt1_vld <= gnt1_vld_d;
    end
  end
endmodule

// File: rtl/fetch_prio_sel_chk.sv
module fetch_prio_sel_chk #(
  parameter int NTHR   = 4,
  parameter int BANK_W = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NTHR-1:0]        ic_miss,
  input logic [NTHR-1:0]        stall,
  input logic [NTHR*BANK_W-1:0] bank,
  input logic [NTHR-1:0]        gnt0,
  input logic                   gnt0_vld,
  input logic [NTHR-1:0]        gnt1,
  input logic                   gnt1_vld
);
  logic [NTHR*BANK_W-1:0] bank_d;
  logic [NTHR-1:0]        stall_d;
  logic [BANK_W-1:0]      b0, b1;

  always_ff @(posedge clk) begin
    bank_d  <= bank;
    stall_d <= stall;
  end

  always_comb begin
    b0 = '0;
    b1 = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (gnt0[t]) b0 = b0 | bank_d[t*BANK_W +: BANK_W];
      if (gnt1[t]) b1 = b1 | bank_d[t*BANK_W +: BANK_W];
    end
  end

  AST_G0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt0) && (gnt0_vld == (gnt0 != '0))); // R4
  AST_G1_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt1) && (gnt1_vld == (gnt1 != '0))); // R4
  AST_G1_NEEDS_G0: assert property (@(posedge clk) disable iff (!rst_n)
    gnt1_vld |-> (gnt0_vld && ((gnt0 & gnt1) == '0))); // R3
  AST_BANK_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    gnt1_vld |-> (b0 != b1)); // R3
  AST_MISS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_miss != '0) |=> (((gnt0 | gnt1) & $past(ic_miss)) == '0)); // R5
  AST_STALL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall & stall_d) != '0) |=> (((gnt0 | gnt1) & $past(stall & stall_d)) == '0)); // R6

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RST_CLEAR: assert (!gnt0_vld && !gnt1_vld && gnt0 == '0 && gnt1 == '0); // R8
    end
  end
endmodule

bind fetch_prio_sel fetch_prio_sel_chk #(.NTHR(NTHR), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ic_miss(ic_miss), .stall(stall), .bank(bank),
  .gnt0(gnt0), .gnt0_vld(gnt0_vld), .gnt1(gnt1), .gnt1_vld(gnt1_vld)
);

// File: tb/sim_fetch_prio_sel.sv
`timescale 1ns/1ps
module sim_fetch_prio_sel;
  localparam int NT = 4;
  localparam int NQ = 4;
  localparam int CW = 5;
  localparam int RD = 4;
  localparam int BW = 1;

  logic              clk;
  logic              rst_n;
  logic [NQ*CW-1:0]    q_cnt;
  logic [NQ*NT-1:0]    q_has;
  logic [NQ*NT*CW-1:0] q_pos;
  logic [NT-1:0]       ic_miss, stall, fetch_vld, fetch_ret;
  logic [NT*BW-1:0]    bank;
  logic [NT-1:0]       gnt0, gnt1;
  logic                gnt0_vld, gnt1_vld;

  fetch_prio_sel #(.NTHR(NT), .NQ(NQ), .CNT_W(CW), .RAS_DEPTH(RD), .BANK_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .q_cnt(q_cnt), .q_has(q_has), .q_pos(q_pos),
    .ic_miss(ic_miss), .stall(stall), .fetch_vld(fetch_vld), .fetch_ret(fetch_ret),
    .bank(bank), .gnt0(gnt0), .gnt0_vld(gnt0_vld), .gnt1(gnt1), .gnt1_vld(gnt1_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state and stimulus
  int m_cnt [NQ];
  bit m_has [NQ][NT];
  int m_pos [NQ][NT];
  int m_bank[NT];
  bit m_miss[NT], m_stall[NT], m_fv[NT], m_fr[NT];
  bit m_stall_prev[NT];
  int m_pops[NT];

  task automatic apply();
    for (int q = 0; q < NQ; q++) begin
      q_cnt[q*CW +: CW] = CW'(m_cnt[q]);
      for (int t = 0; t < NT; t++) begin
        q_has[q*NT+t] = m_has[q][t];
        q_pos[(q*NT+t)*CW +: CW] = CW'(m_pos[q][t]);
      end
    end
    for (int t = 0; t < NT; t++) begin
      ic_miss[t] = m_miss[t]; stall[t] = m_stall[t];
      fetch_vld[t] = m_fv[t]; fetch_ret[t] = m_fr[t];
      bank[t*BW +: BW] = BW'(m_bank[t]);
    end
  endtask

  task automatic clear_all();
    for (int q = 0; q < NQ; q++) begin
      m_cnt[q] = 0;
      for (int t = 0; t < NT; t++) begin m_has[q][t] = 0; m_pos[q][t] = 0; end
    end
    for (int t = 0; t < NT; t++) begin
      m_bank[t] = 0; m_miss[t] = 0; m_stall[t] = 0; m_fv[t] = 0; m_fr[t] = 0;
    end
  endtask

  function automatic int mscore(int t);
    int s = 0;
    for (int q = 0; q < NQ; q++)
      if (m_has[q][t]) s += m_cnt[q] - m_pos[q][t];
    return s;
  endfunction

  function automatic bit melig(int t);
    return !m_miss[t] && !(m_stall[t] && m_stall_prev[t]) && !(m_pops[t] > RD);
  endfunction

  // reference: rank eligible threads, take best, then best in another bank
  task automatic model(output logic [NT-1:0] e0, output logic v0,
                       output logic [NT-1:0] e1, output logic v1);
    int i0 = -1, i1 = -1;
    for (int t = 0; t < NT; t++)
      if (melig(t) && (i0 < 0 || mscore(t) < mscore(i0))) i0 = t;
    for (int t = 0; t < NT; t++)
      if (i0 >= 0 && t != i0 && melig(t) && m_bank[t] != m_bank[i0] &&
          (i1 < 0 || mscore(t) < mscore(i1))) i1 = t;
    e0 = '0; e1 = '0;
    v0 = (i0 >= 0); v1 = (i1 >= 0);
    if (v0) e0[i0] = 1'b1;
    if (v1) e1[i1] = 1'b1;
  endtask

  task automatic chk(string tag, logic [NT-1:0] a0, logic av0, logic [NT-1:0] a1, logic av1,
                     logic [NT-1:0] e0, logic ev0, logic [NT-1:0] e1, logic ev1);
    checks++;
    if (a0 !== e0 || av0 !== ev0 || a1 !== e1 || av1 !== ev1) begin
      errors++;
      $display("FAIL %s: got g0=%b v0=%b g1=%b v1=%b, expected g0=%b v0=%b g1=%b v1=%b",
               tag, a0, av0, a1, av1, e0, ev0, e1, ev1);
    end
  endtask

  // one clock: predict, drive, sample 1 ns after the edge, advance model state
  task automatic cycle(string tag);
    logic [NT-1:0] e0, e1;
    logic v0, v1;
    model(e0, v0, e1, v1);
    apply();
    @(posedge clk); #1;
    for (int t = 0; t < NT; t++) begin
      if (m_fv[t]) m_pops[t] = m_fr[t] ? m_pops[t] + 1 : 0;
      m_stall_prev[t] = m_stall[t];
    end
    chk(tag, gnt0, gnt0_vld, gnt1, gnt1_vld, e0, v0, e1, v1);
  endtask

  task automatic expect_now(string tag, logic [NT-1:0] e0, logic v0, logic [NT-1:0] e1, logic v1);
    chk(tag, gnt0, gnt0_vld, gnt1, gnt1_vld, e0, v0, e1, v1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int t = 0; t < NT; t++) begin m_pops[t] = 0; m_stall_prev[t] = 0; end
    @(posedge clk); @(posedge clk); #1;
    expect_now("R8 outputs cleared in reset", '0, 0, '0, 0);
    rst_n = 1'b1;
  endtask

  // scores: t0=8, t1=6, t2=0, t3=6; banks 0,1,0,1
  task automatic setup_base();
    clear_all();
    for (int q = 0; q < NQ; q++) m_cnt[q] = 10;
    m_has[0][0] = 1; m_pos[0][0] = 2;
    m_has[0][1] = 1; m_pos[0][1] = 9;
    m_has[1][1] = 1; m_pos[1][1] = 5;
    m_has[2][3] = 1; m_pos[2][3] = 7;
    m_has[3][3] = 1; m_pos[3][3] = 7;
    m_bank[1] = 1; m_bank[3] = 1;
  endtask

  task automatic t_score_rank();
    setup_base();
    cycle("R1 R2 score ranking");
    expect_now("R2 R3 tie to lower index", 4'b0100, 1, 4'b0010, 1);
  endtask

  task automatic t_bank_skip();
    setup_base();
    m_bank[0] = 1; m_bank[1] = 0; m_bank[3] = 0;
    cycle("R3 bank skip model");
    expect_now("R3 skip conflicting t1 t3", 4'b0100, 1, 4'b0001, 1);
    m_bank[0] = 0;
    cycle("R4 no non-conflicting second");
    expect_now("R4 gnt1 invalid", 4'b0100, 1, 4'b0000, 0);
  endtask

  task automatic t_miss();
    setup_base();
    m_miss[2] = 1;
    cycle("R5 miss removes t2");
    expect_now("R5 explicit", 4'b0010, 1, 4'b0001, 1);
    // latency: change inputs, outputs hold until the edge
    m_miss[2] = 0; apply(); #2;
    expect_now("R8 outputs stable between edges", 4'b0010, 1, 4'b0001, 1);
    cycle("R8 one cycle latency");
  endtask

  task automatic t_stall();
    setup_base();
    m_stall[2] = 1;
    cycle("R6 first stall cycle keeps t2");
    expect_now("R6 single stall", 4'b0100, 1, 4'b0010, 1);
    cycle("R6 second stall cycle drops t2");
    expect_now("R6 persistent stall", 4'b0010, 1, 4'b0001, 1);
    m_stall[2] = 0;
    cycle("R6 stall released");
  endtask

  task automatic t_pops();
    setup_base();
    m_fv[2] = 1; m_fr[2] = 1;
    for (int i = 0; i < RD + 2; i++) cycle("R7 return run");
    expect_now("R7 excluded past depth", 4'b0010, 1, 4'b0001, 1);
    m_fv[2] = 0;
    cycle("R7 no fetch keeps count");
    m_fv[2] = 1; m_fr[2] = 0;
    cycle("R7 plain fetch clears");
    cycle("R7 eligible after clear");
    expect_now("R7 back after clear", 4'b0100, 1, 4'b0010, 1);
    m_fr[2] = 1;
    for (int i = 0; i < RD + 2; i++) cycle("R7 second return run");
    m_fv[2] = 0;
    do_reset();
    cycle("R8 reset clears return count");
    expect_now("R8 t2 eligible after reset", 4'b0100, 1, 4'b0010, 1);
  endtask

  task automatic t_none();
    setup_base();
    for (int t = 0; t < NT; t++) m_miss[t] = 1;
    cycle("R4 nothing eligible");
    expect_now("R4 both invalid", '0, 0, '0, 0);
    m_miss[0] = 0;
    cycle("R4 single eligible");
    expect_now("R4 only gnt0", 4'b0001, 1, '0, 0);
  endtask

  task automatic t_empty_queue();
    setup_base();
    m_has[0][0] = 0;
    m_pos[0][0] = 1;
    cycle("R1 absent queue adds zero");
    expect_now("R1 t0 score zero wins", 4'b0001, 1, 4'b0010, 1);
  endtask

  initial begin
    clear_all();
    for (int t = 0; t < NT; t++) begin m_pops[t] = 0; m_stall_prev[t] = 0; end
    apply();
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    do_reset();
    t_score_rank();
    t_bank_skip();
    t_miss();
    t_stall();
    t_pops();
    t_none();
    t_empty_queue();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule